// File: doc/BRIEF.md
# Ambient Light Window Interrupt with Persistence Filter

This block turns a stream of completed light-sensor conversions into a single active-low, level-style interrupt. Each time the conversion engine signals that a new channel-0 result is ready, the block compares that result against a programmable window formed by a 16-bit lower bound and a 16-bit upper bound. A result at or below the lower bound, or strictly above the upper bound, is an excursion. Any other result lies inside the window.

A persistence setting suppresses isolated excursions. The interrupt asserts only after a run of consecutive excursions reaches the programmed length. A setting of zero instead raises the interrupt after every conversion, whatever its value. Once asserted, the interrupt stays low until the host issues a clear strobe. A two-bit mode field enables the output. Only one encoding arms it; the other three keep the pin released.

The block sits between a conversion engine and a register file. Both of those, and the serial bus, belong to other blocks. The second photodiode channel never reaches this block.

Top module: `lux_window_irq`

## Requirements
- R1: A channel-0 result `v` is an excursion when `v <= win_low` or `v > win_high`. It is inside the window when `win_low < v <= win_high`.
- R2: With `irq_mode` = 2'b01 and `persist_sel` = 0, every conversion asserts the interrupt, including a result inside the window.
- R3: With `persist_sel` = 1, a single excursion asserts the interrupt.
- R4: With `persist_sel` = N (2 to 15), the interrupt asserts on the Nth consecutive excursion and not before. The run length saturates at 15, so runs longer than 15 keep the interrupt asserted.
- R5: A conversion inside the window restarts the excursion run at zero.
- R6: `irq_mode` = 2'b01 is the only encoding that enables the interrupt. Encodings 2'b00, 2'b10 and 2'b11 hold `irq_n` high, drop a pending interrupt, and restart the run.
- R7: `irq_n` is active low. Once low, it stays low until `irq_clear` is sampled high. It returns high one cycle after that clear.
- R8: `irq_clear` also restarts the excursion run. A conversion sampled with the clear is counted as the first of a new run.
- R9: When a clear and an interrupt-raising conversion are sampled in the same cycle, the interrupt stays asserted.
- R10: After reset, `irq_n` is high and the excursion run is zero.
- R11: The interrupt asserts at the clock edge that samples the qualifying `conv_done`. Without a conversion, `irq_n` never falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe: a new channel-0 result is valid |
| conv_ch0 | input | DATA_W (16) | Channel-0 conversion result |
| win_low | input | DATA_W (16) | Lower window bound (inclusive excursion) |
| win_high | input | DATA_W (16) | Upper window bound (excursion strictly above) |
| irq_mode | input | 2 | Interrupt mode; 2'b01 enables the level interrupt |
| persist_sel | input | PERS_W (4) | Run length required; 0 fires on every conversion |
| irq_clear | input | 1 | One-cycle strobe that releases the interrupt and restarts the run |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The bench builds the block with its default parameters: a 16-bit data path and a 4-bit persistence field. With these values the full persistence range from 0 to 15 can be reached. A 20-conversion run shows that the counter saturates at 15. The window bounds can also be set to the data-path extremes of 0 and 65535, so both comparison edges are tested exactly at their inclusive and exclusive limits.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

  typedef enum logic [1:0] {
    IRQ_OFF   = 2'b00,
    IRQ_LEVEL = 2'b01,
    IRQ_RSV2  = 2'b10,
    IRQ_RSV3  = 2'b11
  } irq_mode_e;

  // Only the level encoding arms the output; reserved codes act as off.
  function automatic logic mode_armed(input logic [1:0] mode);
    return irq_mode_e'(mode) == IRQ_LEVEL;
  endfunction

endpackage

// File: rtl/lwi_window_cmp.sv
module lwi_window_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] lo_bound,
  input  logic [DATA_W-1:0] hi_bound,
  output logic              outside
);

  // Lower edge counts as an excursion; upper edge counts as inside.
  function automatic logic is_excursion(input logic [DATA_W-1:0] v,
                                        input logic [DATA_W-1:0] lo,
                                        input logic [DATA_W-1:0] hi);
    return (v <= lo) || (v > hi);
  endfunction

  assign outside = is_excursion(sample, lo_bound, hi_bound);

endmodule

// File: rtl/lwi_persist.sv
module lwi_persist #(
  parameter int PERS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              conv_done,
  input  logic              outside,
  input  logic              clear,
  input  logic [PERS_W-1:0] persist_sel,
  output logic [PERS_W-1:0] run_cnt,
  output logic              fire
);

  localparam logic [PERS_W-1:0] RUN_MAX = {PERS_W{1'b1}};

  logic [PERS_W-1:0] base_cnt;
  logic [PERS_W-1:0] step_cnt;

  function automatic logic [PERS_W-1:0] sat_inc(input logic [PERS_W-1:0] c);
    return (c == RUN_MAX) ? RUN_MAX : c + 1'b1;
  endfunction

  always_comb begin
    base_cnt = clear ? '0 : run_cnt;
    step_cnt = outside ? sat_inc(base_cnt) : '0;
    fire     = armed && conv_done &&
               ((persist_sel == '0) || (outside && (step_cnt >= persist_sel)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt <= '0;
    else if (!armed)    run_cnt <= '0;
    else if (conv_done) run_cnt <= step_cnt;
    else if (clear)     run_cnt <= '0;
  end

endmodule

// File: rtl/lwi_irq_hold.sv
module lwi_irq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic fire,
  input  logic clear,
  output logic irq_n
);

  logic pending;

  // A new event outranks a coincident clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pending <= 1'b0;
    else if (!armed) pending <= 1'b0;
    else if (fire)   pending <= 1'b1;
    else if (clear)  pending <= 1'b0;
  end

  assign irq_n = ~pending;

endmodule

// File: rtl/lux_window_irq.sv
module lux_window_irq #(
  parameter int DATA_W = 16,
  parameter int PERS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_ch0,
  input  logic [DATA_W-1:0] win_low,
  input  logic [DATA_W-1:0] win_high,
  input  logic [1:0]        irq_mode,
  input  logic [PERS_W-1:0] persist_sel,
  input  logic              irq_clear,
  output logic              irq_n
);

  logic              armed_w;
  logic              outside_w;
  logic              fire_w;
  logic [PERS_W-1:0] run_cnt_w;

  assign armed_w = lwi_pkg::mode_armed(irq_mode);

  lwi_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample   (conv_ch0),
    .lo_bound (win_low),
    .hi_bound (win_high),
    .outside  (outside_w)
  );

  lwi_persist #(.PERS_W(PERS_W)) u_persist (
    .clk         (clk),
    .rst_n       (rst_n),
    .armed       (armed_w),
    .conv_done   (conv_done),
    .outside     (outside_w),
    .clear       (irq_clear),
    .persist_sel (persist_sel),
    .run_cnt     (run_cnt_w),
    .fire        (fire_w)
  );

  lwi_irq_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed_w),
    .fire  (fire_w),
    .clear (irq_clear),
    .irq_n (irq_n)
  );

endmodule

// File: rtl/lwi_checker.sv
module lwi_checker #(
  parameter int PERS_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [1:0]        irq_mode,
  input logic [PERS_W-1:0] persist_sel,
  input logic              irq_clear,
  input logic              irq_n,
  input logic              outside,
  input logic [PERS_W-1:0] run_cnt
);

  AST_ZERO_PERSIST_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && irq_mode == 2'b01 && persist_sel == '0) |=> !irq_n); // R2

  AST_SINGLE_EXCURSION_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && outside && irq_mode == 2'b01 && persist_sel == 1) |=> !irq_n); // R3

  AST_INWINDOW_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !outside && irq_mode == 2'b01) |=> (run_cnt == '0)); // R5

  AST_DISABLED_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode != 2'b01) |=> irq_n); // R6

  AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && irq_mode == 2'b01 && !irq_clear) |=> !irq_n); // R7

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && !conv_done) |=> irq_n); // R7

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && conv_done && outside && irq_mode == 2'b01 && persist_sel == 1) |=> !irq_n); // R9

  AST_NO_EVENT_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_n && !conv_done) |=> irq_n); // R11

endmodule

bind lux_window_irq lwi_checker #(.PERS_W(PERS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_done   (conv_done),
  .irq_mode    (irq_mode),
  .persist_sel (persist_sel),
  .irq_clear   (irq_clear),
  .irq_n       (irq_n),
  .outside     (outside_w),
  .run_cnt     (run_cnt_w)
);

// File: tb/lux_window_irq_tb_top.sv
module lux_window_irq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [15:0] conv_ch0 = '0;
  logic [15:0] win_low = '0;
  logic [15:0] win_high = '0;
  logic [1:0]  irq_mode = 2'b00;
  logic [3:0]  persist_sel = '0;
  logic        irq_clear = 1'b0;
  logic        irq_n;

  always #5 clk = ~clk;

  lux_window_irq dut_i (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_ch0(conv_ch0),
    .win_low(win_low), .win_high(win_high), .irq_mode(irq_mode),
    .persist_sel(persist_sel), .irq_clear(irq_clear), .irq_n(irq_n)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;

  // configuration applied with the next step
  logic [15:0] cfg_lo = 16'd100;
  logic [15:0] cfg_hi = 16'd200;
  logic [1:0]  cfg_mode = 2'b01;
  logic [3:0]  cfg_pers = 4'd0;

  // reference state
  int  m_run = 0;
  bit  m_pend = 0;

  task automatic step(input bit cv, input logic [15:0] v, input bit clr, input string tag);
    bit ow;
    bit hit;
    item_t it;
    @(negedge clk);
    conv_done   = cv;
    conv_ch0    = v;
    irq_clear   = clr;
    win_low     = cfg_lo;
    win_high    = cfg_hi;
    irq_mode    = cfg_mode;
    persist_sel = cfg_pers;
    if (cfg_mode != 2'b01) begin
      m_run = 0; m_pend = 0;
    end else if (cv) begin
      ow = (v <= cfg_lo) || (v > cfg_hi);
      if (clr) m_run = 0;
      m_run = ow ? ((m_run >= 15) ? 15 : m_run + 1) : 0;
      hit = (cfg_pers == 0) || (ow && m_run >= int'(cfg_pers));
      if (hit) m_pend = 1;
      else if (clr) m_pend = 0;
    end else if (clr) begin
      m_run = 0; m_pend = 0;
    end
    it.exp = ~m_pend;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 16'd0, 1'b0, tag);
  endtask

  task automatic clr(input string tag);
    step(1'b0, 16'd0, 1'b1, tag);
  endtask

  // monitor: compares irq_n 2 ns after each edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (irq_n !== it.exp) begin
        errors++;
        $display("FAIL %s: irq_n actual=%b expected=%b at %0t", it.tag, irq_n, it.exp, $time);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (irq_n !== 1'b1) begin
      errors++;
      $display("FAIL R10: reset irq_n actual=%b expected=1", irq_n);
    end
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    if (irq_n !== 1'b1) begin
      errors++;
      $display("FAIL R10: post-reset irq_n actual=%b expected=1", irq_n);
    end

    // R6: every non-level encoding keeps the pin released
    cfg_pers = 0;
    cfg_mode = 2'b00; step(1, 16'd150, 0, "R6 mode00");
    cfg_mode = 2'b10; step(1, 16'd10, 0, "R6 mode10");
    cfg_mode = 2'b11; step(1, 16'd999, 0, "R6 mode11");

    // R2 + R7: persist 0 fires on in-window data, held until clear
    cfg_mode = 2'b01;
    step(1, 16'd150, 0, "R2 in-window fires");
    idle("R7 hold"); idle("R7 hold");
    clr("R7 clear releases");
    idle("R11 no conversion");

    // R1 + R3: window edges with persist 1
    cfg_pers = 1;
    step(1, 16'd150, 0, "R1 inside");
    step(1, 16'd101, 0, "R1 just above low");
    step(1, 16'd100, 0, "R1 equal low is excursion"); clr("R7 clear");
    step(1, 16'd200, 0, "R1 equal high is inside");
    step(1, 16'd201, 0, "R3 above high fires"); clr("R7 clear");
    step(1, 16'd0, 0, "R3 zero fires"); clr("R7 clear");
    step(1, 16'hFFFF, 0, "R3 max fires"); clr("R7 clear");

    // R4: run of 4
    cfg_pers = 4;
    for (int i = 0; i < 4; i++) step(1, 16'd300, 0, "R4 run of 4");
    idle("R7 hold"); clr("R7 clear");

    // R5: in-window restarts the run
    cfg_pers = 3;
    step(1, 16'd50, 0, "R5 excursion");
    step(1, 16'd50, 0, "R5 excursion");
    step(1, 16'd150, 0, "R5 inside restarts");
    step(1, 16'd50, 0, "R5 excursion");
    step(1, 16'd50, 0, "R5 excursion");
    step(1, 16'd50, 0, "R5 third fires"); clr("R7 clear");

    // R8: clear restarts the run
    step(1, 16'd250, 0, "R8 excursion");
    step(1, 16'd250, 0, "R8 excursion");
    clr("R8 clear mid-run");
    step(1, 16'd250, 0, "R8 after clear");
    step(1, 16'd250, 0, "R8 after clear");
    step(1, 16'd250, 0, "R8 third after clear fires");
    step(1, 16'd250, 1, "R8 clear with conv counts as first");
    step(1, 16'd250, 0, "R8 second of new run");
    step(1, 16'd250, 0, "R8 third of new run fires"); clr("R7 clear");

    // R9: event beats clear
    cfg_pers = 1;
    step(1, 16'd5, 0, "R9 fires");
    step(1, 16'd5, 1, "R9 event with clear stays low");
    clr("R9 plain clear");
    step(1, 16'd150, 1, "R9 clear with in-window conv releases");

    // R4 saturation with persist 15
    cfg_pers = 15;
    for (int i = 0; i < 20; i++) step(1, 16'd400, 0, "R4 saturating run");
    clr("R7 clear");
    step(1, 16'd400, 0, "R8 run restarted");

    // R6: disabling drops a pending interrupt
    cfg_pers = 1;
    step(1, 16'd400, 0, "R3 fires");
    cfg_mode = 2'b00; idle("R6 disable releases");
    cfg_mode = 2'b01; idle("R6 stays released");
    idle("R11 no conversion");

    // R1 at data-path extremes
    cfg_lo = 16'd0; cfg_hi = 16'hFFFF;
    step(1, 16'd0, 0, "R1 zero at low=0 is excursion"); clr("R7 clear");
    step(1, 16'd1, 0, "R1 one is inside");
    step(1, 16'hFFFF, 0, "R1 max equals high is inside");
    idle("R11 idle");

    wait (q.size() == 0);
    @(posedge clk); #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule